// File: doc/BRIEF.md
# Synchronous Serial Port Register and Interrupt Unit

This block is the register-facing side of a synchronous serial port. It sits between a simple word-addressed bus and a separate transfer engine that owns the transmit and receive FIFOs and the shift logic. It holds the configuration registers, computes a status word and level interrupts from the FIFO occupancy counts that the engine reports, and drives one interrupt line.

Accesses to the data offset are not stored here. A write becomes a push strobe toward the engine, and a read becomes a pop strobe with the engine's head word returned on the bus. The receive-overrun and receive-timeout conditions arrive as event pulses from the engine. Each is held in a sticky bit until software clears it.

Bus accesses are single-cycle. `bus_sel_i` marks a valid access in the cycle it is high. Read data is combinational from the current state. A register write takes effect at the clock edge that ends the access.

Top module: `ssp_ctrl_regs`

## Requirements
- R1: After reset the interrupt mask reads 0, the status word reads 0x03 while both counts are zero, the raw interrupt word reads 0x8 and `irq_o` is low.
- R2: Status word bit positions are bit0 TX empty (tx count is 0), bit1 TX not full (tx count is not DEPTH), bit2 RX not empty, bit3 RX full (rx count is DEPTH) and bit4 busy (tx count nonzero). The status word is at offset 0x0C.
- R3: The raw interrupt word is at offset 0x18, and its bits 2 and 3 follow the counts every cycle. Bit2 (RX level) is set when the rx count is at least DEPTH/2. Bit3 (TX level) is set when the tx count is at most DEPTH/2.
- R4: The mask is at offset 0x14. The masked word at 0x1C reads raw AND mask, and `irq_o` is high exactly when that AND is nonzero.
- R5: Raw bit0 is set by `overrun_evt_i` and raw bit1 by `timeout_evt_i`. Both stay set until cleared. Writing 1s to offset 0x20 clears bits 0 and 1 only. An event in the same cycle as a clear wins. Bits 2 and 3 are not affected by the clear.
- R6: Writes keep only the low bits of each register: 16 bits at 0x00, 4 bits at 0x04, 8 bits at 0x10 and 4 bits at 0x14. The stored values appear on `ctl0_o`, `ctl1_o` and `presc_o`.
- R7: Offset 0x24 reads as zero. A write to it, including a nonzero one, changes nothing and is not flagged as bad.
- R8: Word offsets 0xFE0 to 0xFFC read one identification byte each: 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R9: A read of an undecoded or unaligned offset returns zero. A write to one is ignored. Either access raises `bad_access_o` for the one cycle after the access.
- R10: A write to offset 0x08 pulses `push_o` only when the tx count is below DEPTH. `push_word_o` carries the write data with bits above the frame size cleared, where the frame size is ctl0 bits 3:0 plus one.
- R11: A read of offset 0x08 pulses `pop_o` and returns `rx_word_i` when the rx count is nonzero. Otherwise it returns zero with no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational |
| bad_access_o | output | 1 | Pulse after an undecoded access |
| tx_count_i | input | CNT_W | Transmit FIFO occupancy |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| rx_word_i | input | DATA_W | Receive FIFO head word |
| overrun_evt_i | input | 1 | Receive overrun event pulse |
| timeout_evt_i | input | 1 | Receive timeout event pulse |
| push_o | output | 1 | Push strobe to the transmit FIFO |
| push_word_o | output | DATA_W | Word to push, masked to the frame size |
| pop_o | output | 1 | Pop strobe from the receive FIFO |
| ctl0_o | output | 16 | Stored control word 0 |
| ctl1_o | output | 4 | Stored control word 1 |
| presc_o | output | 8 | Stored prescaler |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench uses the default build: DEPTH 8, DATA_W 16 and a 12-bit address. Both counts therefore range from 0 to 8, and random draws over that range hit the empty, threshold and full edges of every status and level bit often. The 16-bit data width lets the full range of frame-size masks be exercised on the push path, from 1 bit up to 16. The 12-bit address places the identification block at the real top of the window.

// File: rtl/ssp_regs_pkg.sv
package ssp_regs_pkg;

    localparam int CTL0_W  = 16;
    localparam int CTL1_W  = 4;
    localparam int PRESC_W = 8;
    localparam int IRQ_W   = 4;
    localparam int STAT_W  = 5;
    localparam int BUS_W   = 32;

    // raw interrupt bit positions
    localparam int IRQ_OVR = 0;
    localparam int IRQ_RTO = 1;
    localparam int IRQ_RXL = 2;
    localparam int IRQ_TXL = 3;

    // status bit positions
    localparam int ST_TXE  = 0;
    localparam int ST_TXNF = 1;
    localparam int ST_RXNE = 2;
    localparam int ST_RXF  = 3;
    localparam int ST_BUSY = 4;

    typedef enum logic [3:0] {
        SEL_CTL0, SEL_CTL1, SEL_DATA, SEL_STAT, SEL_PRESC, SEL_MASK,
        SEL_RAW, SEL_MSKD, SEL_CLR, SEL_DMA, SEL_IDENT, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [CTL0_W-1:0]  ctl0;
        logic [CTL1_W-1:0]  ctl1;
        logic [PRESC_W-1:0] presc;
        logic [IRQ_W-1:0]   mask;
        logic [1:0]         sticky;
        logic               bad;
    } cfg_state_t;

    function automatic logic [7:0] ident_byte(input logic [2:0] idx);
        logic [7:0] b;
        unique case (idx)
            3'd0: b = 8'h22;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ssp_addr_decode.sv
module ssp_addr_decode
    import ssp_regs_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o,
    output logic              rd_legal_o,
    output logic              wr_legal_o
);

    localparam int ID_LSB = 5;

    logic aligned;
    logic in_ident;
    logic low_page;

    always_comb begin
        aligned  = (addr_i[1:0] == 2'b00);
        in_ident = &addr_i[ADDR_W-1:ID_LSB];
        low_page = (addr_i[ADDR_W-1:6] == '0);
        sel_o    = SEL_NONE;
        if (aligned && in_ident) begin
            sel_o = SEL_IDENT;
        end else if (aligned && low_page) begin
            unique case (addr_i[5:2])
                4'h0: sel_o = SEL_CTL0;
                4'h1: sel_o = SEL_CTL1;
                4'h2: sel_o = SEL_DATA;
                4'h3: sel_o = SEL_STAT;
                4'h4: sel_o = SEL_PRESC;
                4'h5: sel_o = SEL_MASK;
                4'h6: sel_o = SEL_RAW;
                4'h7: sel_o = SEL_MSKD;
                4'h8: sel_o = SEL_CLR;
                4'h9: sel_o = SEL_DMA;
                default: sel_o = SEL_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (sel_o)
            SEL_CTL0, SEL_CTL1, SEL_DATA, SEL_STAT, SEL_PRESC, SEL_MASK,
            SEL_RAW, SEL_MSKD, SEL_DMA, SEL_IDENT: rd_legal_o = 1'b1;
            default: rd_legal_o = 1'b0;
        endcase
        unique case (sel_o)
            SEL_CTL0, SEL_CTL1, SEL_DATA, SEL_PRESC, SEL_MASK,
            SEL_CLR, SEL_DMA: wr_legal_o = 1'b1;
            default: wr_legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ssp_irq_status.sv
module ssp_irq_status
    import ssp_regs_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic [CNT_W-1:0]  rx_count_i,
    input  logic [1:0]        sticky_i,
    input  logic [IRQ_W-1:0]  mask_i,
    output logic [STAT_W-1:0] status_o,
    output logic [IRQ_W-1:0]  raw_o,
    output logic [IRQ_W-1:0]  masked_o,
    output logic              irq_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    always_comb begin
        status_o          = '0;
        status_o[ST_TXE]  = (tx_count_i == '0);
        status_o[ST_TXNF] = (tx_count_i != FULL_CNT);
        status_o[ST_RXNE] = (rx_count_i != '0);
        status_o[ST_RXF]  = (rx_count_i == FULL_CNT);
        status_o[ST_BUSY] = (tx_count_i != '0);

        raw_o          = '0;
        raw_o[IRQ_OVR] = sticky_i[0];
        raw_o[IRQ_RTO] = sticky_i[1];
        raw_o[IRQ_RXL] = (rx_count_i >= HALF_CNT);
        raw_o[IRQ_TXL] = (tx_count_i <= HALF_CNT);

        masked_o = raw_o & mask_i;
        irq_o    = |masked_o;
    end

endmodule

// File: rtl/ssp_cfg_regs.sv
module ssp_cfg_regs
    import ssp_regs_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  reg_sel_e          sel_i,
    input  logic [BUS_W-1:0]  wdata_i,
    input  logic              overrun_evt_i,
    input  logic              timeout_evt_i,
    input  logic              bad_i,
    output cfg_state_t        state_o
);

    cfg_state_t state_d;
    cfg_state_t state_q;

    always_comb begin
        state_d     = state_q;
        state_d.bad = bad_i;
        if (wr_en_i) begin
            unique case (sel_i)
                SEL_CTL0:  state_d.ctl0   = wdata_i[CTL0_W-1:0];
                SEL_CTL1:  state_d.ctl1   = wdata_i[CTL1_W-1:0];
                SEL_PRESC: state_d.presc  = wdata_i[PRESC_W-1:0];
                SEL_MASK:  state_d.mask   = wdata_i[IRQ_W-1:0];
                SEL_CLR:   state_d.sticky = state_q.sticky & ~wdata_i[1:0];
                default:   ;
            endcase
        end
        // a new event outranks a clear in the same cycle
        if (overrun_evt_i) state_d.sticky[0] = 1'b1;
        if (timeout_evt_i) state_d.sticky[1] = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/ssp_ctrl_regs.sv
module ssp_ctrl_regs
    import ssp_regs_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               bad_access_o,
    input  logic [CNT_W-1:0]   tx_count_i,
    input  logic [CNT_W-1:0]   rx_count_i,
    input  logic [DATA_W-1:0]  rx_word_i,
    input  logic               overrun_evt_i,
    input  logic               timeout_evt_i,
    output logic               push_o,
    output logic [DATA_W-1:0]  push_word_o,
    output logic               pop_o,
    output logic [15:0]        ctl0_o,
    output logic [3:0]         ctl1_o,
    output logic [7:0]         presc_o,
    output logic               irq_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam int               SIZE_W   = 4;

    reg_sel_e          sel_w;
    logic              rd_legal_w;
    logic              wr_legal_w;
    logic              wr_en_w;
    logic              bad_w;
    cfg_state_t        cfg_q;
    logic [STAT_W-1:0] status_w;
    logic [IRQ_W-1:0]  raw_w;
    logic [IRQ_W-1:0]  masked_w;
    logic [IRQ_W-1:0]  mask_q;
    logic [SIZE_W-1:0] frame_msb;

    ssp_addr_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr_i     (bus_addr_i),
        .sel_o      (sel_w),
        .rd_legal_o (rd_legal_w),
        .wr_legal_o (wr_legal_w)
    );

    always_comb begin
        wr_en_w = bus_sel_i && bus_wr_i && wr_legal_w;
        bad_w   = bus_sel_i && (bus_wr_i ? !wr_legal_w : !rd_legal_w);
    end

    ssp_cfg_regs i_cfg (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_en_i       (wr_en_w),
        .sel_i         (sel_w),
        .wdata_i       (bus_wdata_i),
        .overrun_evt_i (overrun_evt_i),
        .timeout_evt_i (timeout_evt_i),
        .bad_i         (bad_w),
        .state_o       (cfg_q)
    );

    assign mask_q = cfg_q.mask;

    ssp_irq_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_status (
        .tx_count_i (tx_count_i),
        .rx_count_i (rx_count_i),
        .sticky_i   (cfg_q.sticky),
        .mask_i     (mask_q),
        .status_o   (status_w),
        .raw_o      (raw_w),
        .masked_o   (masked_w),
        .irq_o      (irq_o)
    );

    // transmit word keeps bits up to the programmed frame size
    assign frame_msb = cfg_q.ctl0[SIZE_W-1:0];

    for (genvar g = 0; g < DATA_W; g++) begin : g_push_mask
        assign push_word_o[g] = bus_wdata_i[g] && (g <= int'(frame_msb));
    end

    always_comb begin
        push_o = bus_sel_i && bus_wr_i && (sel_w == SEL_DATA)
                 && (tx_count_i < FULL_CNT);
    end

    always_comb begin
        bus_rdata_o = '0;
        pop_o       = 1'b0;
        if (bus_sel_i && !bus_wr_i) begin
            unique case (sel_w)
                SEL_CTL0:  bus_rdata_o[CTL0_W-1:0]  = cfg_q.ctl0;
                SEL_CTL1:  bus_rdata_o[CTL1_W-1:0]  = cfg_q.ctl1;
                SEL_PRESC: bus_rdata_o[PRESC_W-1:0] = cfg_q.presc;
                SEL_MASK:  bus_rdata_o[IRQ_W-1:0]   = cfg_q.mask;
                SEL_STAT:  bus_rdata_o[STAT_W-1:0]  = status_w;
                SEL_RAW:   bus_rdata_o[IRQ_W-1:0]   = raw_w;
                SEL_MSKD:  bus_rdata_o[IRQ_W-1:0]   = masked_w;
                SEL_IDENT: bus_rdata_o[7:0]         = ident_byte(bus_addr_i[4:2]);
                SEL_DATA: begin
                    if (rx_count_i != '0) begin
                        bus_rdata_o[DATA_W-1:0] = rx_word_i;
                        pop_o                   = 1'b1;
                    end
                end
                default: bus_rdata_o = '0;
            endcase
        end
    end

    assign bad_access_o = cfg_q.bad;
    assign ctl0_o       = cfg_q.ctl0;
    assign ctl1_o       = cfg_q.ctl1;
    assign presc_o      = cfg_q.presc;

endmodule

// File: rtl/ssp_ctrl_regs_chk.sv
module ssp_ctrl_regs_chk #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [CNT_W-1:0]  tx_count_i,
    input logic [CNT_W-1:0]  rx_count_i,
    input logic              overrun_evt_i,
    input logic              push_o,
    input logic              pop_o,
    input logic              bad_access_o,
    input logic              irq_o,
    input logic [3:0]        mask_i,
    input logic [3:0]        raw_i
);

    // R10: no push toward a full transmit FIFO
    a_r10_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_count_i == CNT_W'(DEPTH)) |-> !push_o);

    // R11: no pop from an empty receive FIFO
    a_r11_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_count_i == '0) |-> !pop_o);

    // R9: an idle bus cycle leaves no bad flag in the next cycle
    a_r9_idle_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bus_sel_i |=> !bad_access_o);

    // R9: an unaligned access is flagged one cycle later
    a_r9_unaligned_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && (bus_addr_i[1:0] != 2'b00)) |=> bad_access_o);

    // R5: an overrun event is visible in the raw word next cycle
    a_r5_overrun_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_evt_i |=> raw_i[0]);

    // R3: TX level with its mask bit set drives the interrupt
    a_r3_tx_level_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((tx_count_i <= CNT_W'(DEPTH / 2)) && mask_i[3]) |-> irq_o);

    // R4: an all-zero mask keeps the line low
    a_r4_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == 4'h0) |-> !irq_o);

endmodule

bind ssp_ctrl_regs ssp_ctrl_regs_chk #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bus_sel_i     (bus_sel_i),
    .bus_wr_i      (bus_wr_i),
    .bus_addr_i    (bus_addr_i),
    .tx_count_i    (tx_count_i),
    .rx_count_i    (rx_count_i),
    .overrun_evt_i (overrun_evt_i),
    .push_o        (push_o),
    .pop_o         (pop_o),
    .bad_access_o  (bad_access_o),
    .irq_o         (irq_o),
    .mask_i        (mask_q),
    .raw_i         (raw_w)
);

// File: tb/test_ssp_ctrl_regs.sv
module test_ssp_ctrl_regs;

    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel = 1'b0;
    logic              wr = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              bad;
    logic [CNT_W-1:0]  txc = '0;
    logic [CNT_W-1:0]  rxc = '0;
    logic [DATA_W-1:0] rxw = '0;
    logic              ovr = 1'b0;
    logic              rto = 1'b0;
    logic              push;
    logic [DATA_W-1:0] pword;
    logic              pop;
    logic [15:0]       ctl0;
    logic [3:0]        ctl1;
    logic [7:0]        presc;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ssp_ctrl_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ssp_ctrl_regs (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .bad_access_o(bad), .tx_count_i(txc), .rx_count_i(rxc),
        .rx_word_i(rxw), .overrun_evt_i(ovr), .timeout_evt_i(rto),
        .push_o(push), .push_word_o(pword), .pop_o(pop),
        .ctl0_o(ctl0), .ctl1_o(ctl1), .presc_o(presc), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(input int t, input int r);
        logic [31:0] s = '0;
        s[0] = (t == 0); s[1] = (t != DEPTH); s[2] = (r != 0);
        s[3] = (r == DEPTH); s[4] = (t != 0);
        return s;
    endfunction

    function automatic logic [31:0] exp_raw(input int t, input int r, input logic [1:0] st);
        logic [31:0] s = '0;
        s[1:0] = st; s[2] = (r >= DEPTH / 2); s[3] = (t <= DEPTH / 2);
        return s;
    endfunction

    // one bus access; outputs sampled mid-cycle
    task automatic acc(input logic w, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic ps, output logic pp,
                       output logic [DATA_W-1:0] pw);
        @(negedge clk);
        sel = 1'b1; wr = w; addr = a; wdata = d;
        #1;
        rd = rdata; ps = push; pp = pop; pw = pword;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic wreg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        logic [31:0] r; logic ps, pp; logic [DATA_W-1:0] pw;
        acc(1'b1, a, d, r, ps, pp, pw);
    endtask

    task automatic rreg(input logic [ADDR_W-1:0] a, output logic [31:0] r);
        logic ps, pp; logic [DATA_W-1:0] pw;
        acc(1'b0, a, 32'h0, r, ps, pp, pw);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic ps, pp;
        logic [DATA_W-1:0] pw;
        logic [1:0] st;
        logic [3:0] msk;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rreg(12'h014, r); check("R1 mask", r, 32'h0);
        rreg(12'h00C, r); check("R1 status", r, 32'h3);
        rreg(12'h018, r); check("R1 raw", r, 32'h8);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R8 identification bytes
        for (int i = 0; i < 8; i++) begin
            logic [7:0] idb [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            rreg(ADDR_W'(12'hFE0 + 4 * i), r);
            check("R8 ident", r, {24'h0, idb[i]});
        end

        // R6 width truncation
        wreg(12'h000, 32'hFFFF_FFFF); rreg(12'h000, r); check("R6 ctl0", r, 32'hFFFF);
        wreg(12'h004, 32'hFFFF_FFFF); rreg(12'h004, r); check("R6 ctl1", r, 32'hF);
        wreg(12'h010, 32'hFFFF_FFFF); rreg(12'h010, r); check("R6 presc", r, 32'hFF);
        wreg(12'h014, 32'hFFFF_FFFF); rreg(12'h014, r); check("R6 mask", r, 32'hF);
        check("R6 outputs", {ctl0, ctl1, presc, 4'h0}, {16'hFFFF, 4'hF, 8'hFF, 4'h0});
        wreg(12'h014, 32'h0);

        // R7 DMA control
        wreg(12'h024, 32'h3);
        check("R7 no bad flag", {31'h0, bad}, 32'h0);
        rreg(12'h024, r); check("R7 reads zero", r, 32'h0);
        rreg(12'h000, r); check("R7 ctl0 untouched", r, 32'hFFFF);

        // R9 undecoded accesses
        rreg(12'h028, r); check("R9 read zero", r, 32'h0);
        check("R9 bad after read", {31'h0, bad}, 32'h1);
        @(negedge clk); check("R9 bad one cycle", {31'h0, bad}, 32'h0);
        wreg(12'h101, 32'h12);
        check("R9 bad after write", {31'h0, bad}, 32'h1);
        wreg(12'h020, 32'h0);
        check("R9 clear reg write legal", {31'h0, bad}, 32'h0);
        rreg(12'h020, r);
        check("R9 clear reg read flagged", {31'h0, bad}, 32'h1);
        rreg(12'h010, r); check("R9 presc untouched", r, 32'hFF);

        // R5 sticky events and clear
        txc = 4'd2; rxc = 4'd5;
        @(negedge clk); ovr = 1'b1; rto = 1'b1;
        @(negedge clk); ovr = 1'b0; rto = 1'b0;
        rreg(12'h018, r); check("R5 both set", r, 32'hF);
        wreg(12'h020, 32'h1);
        rreg(12'h018, r); check("R5 clear bit0 only", r, 32'hE);
        wreg(12'h020, 32'hF);
        rreg(12'h018, r); check("R5 level bits kept", r, 32'hC);
        @(negedge clk);
        ovr = 1'b1; sel = 1'b1; wr = 1'b1; addr = 12'h020; wdata = 32'h1;
        @(negedge clk);
        ovr = 1'b0; sel = 1'b0; wr = 1'b0;
        rreg(12'h018, r); check("R5 event beats clear", r, 32'hD);
        wreg(12'h020, 32'h3);

        // R10 push strobes and frame masking
        wreg(12'h000, 32'h0007);
        txc = 4'd8;
        acc(1'b1, 12'h008, 32'hABCD, r, ps, pp, pw);
        check("R10 no push when full", {31'h0, ps}, 32'h0);
        txc = 4'd3;
        acc(1'b1, 12'h008, 32'hABCD, r, ps, pp, pw);
        check("R10 push", {31'h0, ps}, 32'h1);
        check("R10 word 8b", {16'h0, pw}, 32'h00CD);
        wreg(12'h000, 32'h0003);
        acc(1'b1, 12'h008, 32'hABCD, r, ps, pp, pw);
        check("R10 word 4b", {16'h0, pw}, 32'h000D);

        // R11 pop strobes
        rxc = 4'd0; rxw = 16'h5A5A;
        acc(1'b0, 12'h008, 32'h0, r, ps, pp, pw);
        check("R11 empty reads zero", r, 32'h0);
        check("R11 no pop", {31'h0, pp}, 32'h0);
        rxc = 4'd2;
        acc(1'b0, 12'h008, 32'h0, r, ps, pp, pw);
        check("R11 data", r, 32'h5A5A);
        check("R11 pop", {31'h0, pp}, 32'h1);

        // R2 R3 R4 random sweep against bench model
        st = 2'b00; msk = 4'h0;
        for (int it = 0; it < 300; it++) begin
            int t, rr;
            t = int'($urandom_range(0, DEPTH));
            rr = int'($urandom_range(0, DEPTH));
            @(negedge clk);
            txc = CNT_W'(t); rxc = CNT_W'(rr);
            if ($urandom_range(0, 3) == 0) begin
                msk = 4'($urandom());
                wreg(12'h014, {28'h0, msk});
            end
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk); ovr = 1'b1;
                @(negedge clk); ovr = 1'b0;
                st[0] = 1'b1;
            end
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk); rto = 1'b1;
                @(negedge clk); rto = 1'b0;
                st[1] = 1'b1;
            end
            if ($urandom_range(0, 3) == 0) begin
                logic [31:0] c = 32'($urandom());
                wreg(12'h020, c);
                st = st & ~c[1:0];
            end
            rreg(12'h00C, r); check("R2 status", r, exp_stat(t, rr));
            rreg(12'h018, r); check("R3 raw", r, exp_raw(t, rr, st));
            rreg(12'h01C, r); check("R4 masked", r, exp_raw(t, rr, st) & {28'h0, msk});
            check("R4 irq", {31'h0, irq}, {31'h0, |(exp_raw(t, rr, st) & {28'h0, msk})});
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule